// File: doc/BRIEF.md
# Vectored Interrupt Peripheral Interface

This block is the peripheral end of interrupt-driven input. Words from the outside world arrive on a valid/ready stream and are latched into a receive register on the system bus. Holding an unread word raises a request on an interrupt line that several peripherals may share. When the processor acknowledges that request, the block puts its own service-routine vector on the read data bus. The service routine then reads the receive register, and that read withdraws the request.

The service routine can write a processed result into a transmit register. That register drives an output toward a consumer, together with a one-cycle update strobe. A status register reports whether a word is pending. It also holds a sticky flag that records a word lost to overwrite.

The input stream never applies back-pressure: `in_ready` is always high. A word accepted while the previous one is still unread replaces it and sets the overrun flag. The read data bus carries zero whenever the block is not answering, so it can be OR-combined with the read data of other bus slaves. Reset is synchronous.

Top module: `vec_irq_periph`

## Requirements
- R1: A cycle with `in_valid` high loads `in_data` into the receive register at address 0x8000 on that clock edge. `in_ready` is always 1.
- R2: `irq` is registered. It goes high on the edge that samples `in_valid` and stays high until the receive register is read.
- R3: While `inta` is high, `rdata` equals the parameter `VECTOR` (default 16), whatever the read strobe and address are.
- R4: A bus read of 0x8000 returns the held word in the same cycle, and `irq` is low after that edge. The exception is a cycle in which `in_valid` is also high: the new word is then held and `irq` stays high.
- R5: A bus write to 0x8001 loads `wdata` into `tx_data` on that edge and pulses `tx_update` high for exactly the following cycle. A read of 0x8001 returns `tx_data`.
- R6: A read of 0x8002 returns the status register, with bit 0 the overrun flag and bit 1 the word-pending flag (equal to `irq`). Overrun is set when `in_valid` arrives while a word is pending and the same cycle does not read 0x8000. A read of the status register clears overrun, unless overrun is set in that same cycle.
- R7: `rdata` is 0 when `inta` is low and either `rd_en` is low or `addr` is not one of 0x8000, 0x8001 or 0x8002.
- R8: A synchronous reset clears the receive register, the transmit register, `tx_update`, `irq` and both status flags.
- R9: Bus writes to 0x8000, to 0x8002 or to any unmapped address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Incoming word valid |
| in_ready | output | 1 | Always 1; the stream is never stalled |
| in_data | input | DATA_W | Incoming word |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Bus write data |
| rd_en | input | 1 | Bus read strobe |
| wr_en | input | 1 | Bus write strobe |
| rdata | output | DATA_W | Bus read data; 0 when the block is not answering |
| irq | output | 1 | Shared interrupt request |
| inta | input | 1 | Interrupt acknowledge from the processor |
| tx_data | output | DATA_W | Transmit register contents |
| tx_update | output | 1 | One-cycle pulse after each transmit write |

## Verification
The hardest state to reach is a collision between an arriving word and a bus read in the same cycle. Two collisions matter. In the first, the receive register is read while a new word lands, which must keep the request up and must not count as an overrun. In the second, the status register is read while an overrun is being set, and the flag must survive the clear.

The bench drives both collisions. It loads a word first, then presents the second word and the read strobe on the same falling edge, so both are sampled on one rising edge. Afterwards it reads the status and receive registers to observe what the block kept. A full sweep of all 256 byte values runs through the capture, acknowledge and read sequence, and another through the transmit register.

// File: rtl/vip_pkg.sv
package vip_pkg;
  // Register offsets from the block base address; the service routine relies on them.
  localparam int RX_OFS   = 0;
  localparam int TX_OFS   = 1;
  localparam int STAT_OFS = 2;

  // Status register bit positions.
  localparam int STAT_OVR_BIT  = 0;
  localparam int STAT_FULL_BIT = 1;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_RX,
    SEL_TX,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/vip_decode.sv
module vip_decode
  import vip_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] RX_ADDR   = BASE_ADDR + ADDR_W'(RX_OFS);
  localparam logic [ADDR_W-1:0] TX_ADDR   = BASE_ADDR + ADDR_W'(TX_OFS);
  localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + ADDR_W'(STAT_OFS);

  always_comb begin
    if (addr == RX_ADDR)        sel = SEL_RX;
    else if (addr == TX_ADDR)   sel = SEL_TX;
    else if (addr == STAT_ADDR) sel = SEL_STAT;
    else                        sel = SEL_NONE;
  end
endmodule

// File: rtl/vip_rx_capture.sv
module vip_rx_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rx_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              full,
  output logic              overrun
);
  logic lost_word;

  // A word is lost only if one is pending and this cycle does not consume it.
  assign lost_word = in_valid & full & ~rx_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      full    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (in_valid) rx_data <= in_data;
      full    <= in_valid | (full & ~rx_rd);
      overrun <= lost_word | (overrun & ~stat_rd);
    end
  end
endmodule

// File: rtl/vip_tx_register.sv
module vip_tx_register #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_update
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data   <= '0;
      tx_update <= 1'b0;
    end else begin
      tx_update <= tx_wr;
      if (tx_wr) tx_data <= wdata;
    end
  end
endmodule

// File: rtl/vip_read_mux.sv
module vip_read_mux
  import vip_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] VECTOR = 8'd16
) (
  input  logic              inta,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rdata
);
  // The acknowledge takes priority; otherwise only a read of an own register drives the bus.
  always_comb begin
    rdata = '0;
    if (inta) begin
      rdata = VECTOR;
    end else if (rd_en) begin
      unique case (sel)
        SEL_RX:   rdata = rx_data;
        SEL_TX:   rdata = tx_data;
        SEL_STAT: rdata = status;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vec_irq_periph.sv
module vec_irq_periph
  import vip_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000,
  parameter logic [DATA_W-1:0] VECTOR    = 8'd16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  input  logic              inta,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_update
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] rx_data;
  logic [DATA_W-1:0] status;
  logic              full;
  logic              overrun;
  logic              rx_rd;
  logic              stat_rd;
  logic              tx_wr;

  assign in_ready = 1'b1;

  vip_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .addr(addr),
    .sel (sel)
  );

  // A read cycle answered by the vector has no side effect on the registers.
  assign rx_rd   = rd_en & ~inta & (sel == SEL_RX);
  assign stat_rd = rd_en & ~inta & (sel == SEL_STAT);
  assign tx_wr   = wr_en & (sel == SEL_TX);

  vip_rx_capture #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_data (in_data),
    .rx_rd   (rx_rd),
    .stat_rd (stat_rd),
    .rx_data (rx_data),
    .full    (full),
    .overrun (overrun)
  );

  vip_tx_register #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .tx_wr    (tx_wr),
    .wdata    (wdata),
    .tx_data  (tx_data),
    .tx_update(tx_update)
  );

  always_comb begin
    status                = '0;
    status[STAT_OVR_BIT]  = overrun;
    status[STAT_FULL_BIT] = full;
  end

  vip_read_mux #(
    .DATA_W(DATA_W),
    .VECTOR(VECTOR)
  ) u_rmux (
    .inta   (inta),
    .rd_en  (rd_en),
    .sel    (sel),
    .rx_data(rx_data),
    .tx_data(tx_data),
    .status (status),
    .rdata  (rdata)
  );

  assign irq = full;
endmodule

// File: rtl/vip_checker.sv
module vip_checker #(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000,
  parameter logic [DATA_W-1:0] VECTOR    = 8'd16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              inta,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_update
);
  logic rx_hit, tx_hit;
  assign rx_hit = (addr == BASE_ADDR);
  assign tx_hit = (addr == BASE_ADDR + ADDR_W'(1));

  assert_capture_irq_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> irq);

  assert_irq_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (irq && !(rd_en && !inta && rx_hit)) |=> irq);

  assert_vector_R3: assert property (@(posedge clk) disable iff (rst)
    inta |-> (rdata == VECTOR));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !inta && rx_hit && !in_valid) |=> !irq);

  assert_tx_write_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tx_hit) |=> (tx_update && tx_data == $past(wdata)));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!inta && !rd_en) |-> (rdata == '0));

  assert_reset_clear_R8: assert property (@(posedge clk)
    $past(rst) |-> (!irq && !tx_update && tx_data == '0));
endmodule

bind vec_irq_periph vip_checker #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR),
  .VECTOR   (VECTOR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .addr     (addr),
  .wdata    (wdata),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .rdata    (rdata),
  .irq      (irq),
  .inta     (inta),
  .tx_data  (tx_data),
  .tx_update(tx_update)
);

// File: tb/tb_vec_irq_periph.sv
module tb_vec_irq_periph;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam logic [AW-1:0] A_RX   = 16'h8000;
  localparam logic [AW-1:0] A_TX   = 16'h8001;
  localparam logic [AW-1:0] A_STAT = 16'h8002;
  localparam logic [DW-1:0] VEC    = 8'd16;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          rd_en;
  logic          wr_en;
  logic [DW-1:0] rdata;
  logic          irq;
  logic          inta;
  logic [DW-1:0] tx_data;
  logic          tx_update;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  vec_irq_periph dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .addr(addr), .wdata(wdata), .rd_en(rd_en),
    .wr_en(wr_en), .rdata(rdata), .irq(irq), .inta(inta),
    .tx_data(tx_data), .tx_update(tx_update)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // Advance one cycle: inputs are driven on falling edges only.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0; rd_en = 1'b0; wr_en = 1'b0; inta = 1'b0;
    addr = '0; wdata = '0; in_data = '0;
  endtask

  task automatic push(input logic [DW-1:0] v);
    in_valid = 1'b1; in_data = v;
    step();
    in_valid = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input int exp, input string req);
    rd_en = 1'b1; addr = a;
    #1 chk_eq(req, int'(rdata), exp);
    step();
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] v);
    wr_en = 1'b1; addr = a; wdata = v;
    step();
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    @(negedge clk); step();
    rst = 1'b0;

    // R8: reset state
    chk_eq("R8 irq", int'(irq), 0);
    chk_eq("R8 tx_data", int'(tx_data), 0);
    chk_eq("R8 tx_update", int'(tx_update), 0);
    chk_eq("R7 idle rdata", int'(rdata), 0);
    bus_rd(A_STAT, 0, "R8 status");
    bus_rd(A_RX, 0, "R8 rx");

    // R1..R4 sweep over every byte value
    for (int v = 0; v < 256; v++) begin
      chk_eq("R1 in_ready", int'(in_ready), 1);
      push(DW'(v));
      chk_eq("R2 irq after capture", int'(irq), 1);
      step();
      chk_eq("R2 irq held", int'(irq), 1);
      inta = 1'b1; rd_en = 1'b1; addr = A_RX;
      #1 chk_eq("R3 vector", int'(rdata), int'(VEC));
      step();
      inta = 1'b0; rd_en = 1'b0; addr = '0;
      chk_eq("R3 ack read has no side effect", int'(irq), 1);
      bus_rd(A_RX, v, "R1 rx value");
      chk_eq("R4 irq cleared", int'(irq), 0);
    end

    // R6: overrun by two unread words
    push(8'h11);
    push(8'h22);
    bus_rd(A_STAT, 3, "R6 overrun and full");
    bus_rd(A_STAT, 2, "R6 overrun cleared by read");
    bus_rd(A_RX, 8'h22, "R6 newest word kept");
    bus_rd(A_STAT, 0, "R6 status empty");

    // R4/R6: new word lands in the same cycle as the receive read
    push(8'h33);
    in_valid = 1'b1; in_data = 8'h44; rd_en = 1'b1; addr = A_RX;
    #1 chk_eq("R4 collision read old", int'(rdata), 8'h33);
    step();
    in_valid = 1'b0; rd_en = 1'b0; addr = '0;
    chk_eq("R4 collision irq stays", int'(irq), 1);
    bus_rd(A_STAT, 2, "R6 collision no overrun");
    bus_rd(A_RX, 8'h44, "R4 collision new word");

    // R6: overrun set during a status read survives the clear
    push(8'h55);
    in_valid = 1'b1; in_data = 8'h66; rd_en = 1'b1; addr = A_STAT;
    #1 chk_eq("R6 status before set", int'(rdata), 2);
    step();
    in_valid = 1'b0; rd_en = 1'b0; addr = '0;
    bus_rd(A_STAT, 3, "R6 set wins over clear");
    bus_rd(A_RX, 8'h66, "R6 rx after overrun");
    bus_rd(A_STAT, 0, "R6 final status");

    // R5: transmit register sweep
    for (int v = 0; v < 256; v++) begin
      bus_wr(A_TX, DW'(v));
      chk_eq("R5 tx_data", int'(tx_data), v);
      chk_eq("R5 tx_update pulse", int'(tx_update), 1);
      step();
      chk_eq("R5 tx_update single", int'(tx_update), 0);
      if (v % 32 == 0) bus_rd(A_TX, v, "R5 tx readback");
    end

    // R7: unmapped reads return zero
    bus_rd(16'h8003, 0, "R7 above map");
    bus_rd(16'h7FFF, 0, "R7 below map");
    bus_rd(16'h0000, 0, "R7 zero addr");

    // R9: writes to read-only or unmapped addresses
    bus_wr(A_TX, 8'h5A);
    push(8'h77);
    bus_wr(A_RX, 8'hAA);
    bus_wr(A_STAT, 8'hFF);
    bus_wr(16'h0001, 8'hC3);
    chk_eq("R9 tx untouched", int'(tx_data), 8'h5A);
    bus_rd(A_STAT, 2, "R9 status untouched");
    bus_rd(A_RX, 8'h77, "R9 rx untouched");

    // R8: reset in the middle of activity
    push(8'h88);
    push(8'h99);
    bus_wr(A_TX, 8'h3C);
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk_eq("R8 irq after reset", int'(irq), 0);
    chk_eq("R8 tx after reset", int'(tx_data), 0);
    chk_eq("R8 tx_update after reset", int'(tx_update), 0);
    bus_rd(A_STAT, 0, "R8 status after reset");
    bus_rd(A_RX, 0, "R8 rx after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule